// File: doc/BRIEF.md
# Branch Resolution Unit

This unit settles the outcome of control-flow instructions in a 32-bit pipelined core. For each valid instruction it receives the program counter, the 6-bit opcode and the 26-bit immediate or address field. It also receives the two source register values and the direction and target that the front end predicted. From these it works out whether the instruction really transfers control and which address must be fetched next. It also raises a flag when the prediction was wrong, so the front end can discard younger work and refetch.

Four conditional branches compare two register values: equal, not equal, signed less-than and signed greater-than. A taken branch lands at the address after the branch plus four times a signed 16-bit offset. An unconditional jump always transfers control, to an absolute word index taken from its 26-bit field. The comparison, the target arithmetic and the check against the prediction are all combinational. One register stage holds the result.

Top module: `brn_resolve`

## Requirements
- R1: Opcodes decoded: 6'b100000 equal-branch, 6'b100001 not-equal-branch, 6'b100010 less-than-branch, 6'b100011 greater-than-branch, 6'b100100 jump. Any other opcode, including the rest of 6'b100000..6'b101111, yields res_valid_o, taken_o, mispredict_o low and next_pc_o zero one cycle later.
- R2: The equal branch is taken when rd_val_i equals rs_val_i. The not-equal branch is taken when they differ.
- R3: The less-than branch is taken when rd_val_i < rs_val_i, and the greater-than branch when rd_val_i > rs_val_i, both as signed two's-complement values.
- R4: A taken conditional branch gives next_pc_o = pc_i + 4 + 4*sext(imm_i[15:0]). Bits imm_i[25:16] have no effect on branches, and negative offsets branch backward.
- R5: A branch that is not taken gives next_pc_o = pc_i + 4.
- R6: A jump is always taken, with next_pc_o = {4'b0, imm_i[25:0], 2'b00}, independent of pc_i.
- R7: mispredict_o is high when the actual direction differs from pred_taken_i.
- R8: When both the actual and the predicted direction are taken, mispredict_o is high exactly when pred_target_i differs from next_pc_o. pred_target_i has no effect when pred_taken_i is low.
- R9: Results appear on the outputs one clock after valid_i is sampled. A cycle with valid_i low gives all outputs low or zero on the next cycle.
- R10: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| pc_i | input | 32 | Address of the instruction |
| opcode_i | input | 6 | Instruction opcode |
| imm_i | input | 26 | Immediate (low 16 bits) or jump address field |
| rd_val_i | input | 32 | First compared register value |
| rs_val_i | input | 32 | Second compared register value |
| pred_taken_i | input | 1 | Predicted direction |
| pred_target_i | input | 32 | Predicted target address |
| res_valid_o | output | 1 | A control instruction was resolved |
| taken_o | output | 1 | Actual direction |
| next_pc_o | output | 32 | Correct next fetch address |
| mispredict_o | output | 1 | Prediction was wrong; flush and redirect |

## Verification
Every output is due exactly one rising edge after the inputs it depends on are sampled, because a single register stage lies between them. The bench applies a new instruction on each falling edge. It computes the expected direction, address and flag from its own model at that moment. It compares all four outputs at the next falling edge, after exactly one rising edge, so every result is read in the cycle it is due and never on an edge.

// File: rtl/brn_pkg.sv
package brn_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_BEQ = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_BLT = 6'b100010;
  localparam logic [OPC_W-1:0] OPC_BGT = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_JMP = 6'b100100;

  typedef enum logic [2:0] {
    K_NONE, K_EQ, K_NE, K_LT, K_GT, K_JMP
  } ctrl_kind_e;

  function automatic ctrl_kind_e decode_kind(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_BEQ: decode_kind = K_EQ;
      OPC_BNE: decode_kind = K_NE;
      OPC_BLT: decode_kind = K_LT;
      OPC_BGT: decode_kind = K_GT;
      OPC_JMP: decode_kind = K_JMP;
      default: decode_kind = K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/brn_cond.sv
module brn_cond
  import brn_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  ctrl_kind_e      kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            taken_o
);
  logic eq, lt, gt;

  always_comb begin
    eq = (a_i == b_i);
    lt = ($signed(a_i) < $signed(b_i));
    gt = ($signed(a_i) > $signed(b_i));
    case (kind_i)
      K_EQ:    taken_o = eq;
      K_NE:    taken_o = !eq;
      K_LT:    taken_o = lt;
      K_GT:    taken_o = gt;
      K_JMP:   taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brn_target.sv
module brn_target #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned ADDR_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [ADDR_W-1:0] field_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   br_tgt_o,
  output logic [XLEN-1:0]   jmp_tgt_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned ZEXT_W = XLEN - ADDR_W - 2;

  logic [XLEN-1:0] br_off;

  assign br_off    = {{SEXT_W{field_i[IMM_W-1]}}, field_i[IMM_W-1:0], 2'b00};
  assign seq_pc_o  = pc_i + XLEN'(4);
  assign br_tgt_o  = seq_pc_o + br_off;
  assign jmp_tgt_o = {{ZEXT_W{1'b0}}, field_i, 2'b00};
endmodule

// File: rtl/brn_resolve.sv
module brn_resolve
  import brn_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [XLEN-1:0]   rd_val_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              pred_taken_i,
  input  logic [XLEN-1:0]   pred_target_i,
  output logic              res_valid_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              mispredict_o
);
  ctrl_kind_e      kind;
  logic            is_ctrl, act_taken, mis_d;
  logic [XLEN-1:0] seq_pc, br_tgt, jmp_tgt, npc_d;

  assign kind    = decode_kind(opcode_i);
  assign is_ctrl = valid_i && (kind != K_NONE);

  brn_cond #(.XLEN(XLEN)) u_cond (
    .kind_i (kind),
    .a_i    (rd_val_i),
    .b_i    (rs_val_i),
    .taken_o(act_taken)
  );

  brn_target #(.XLEN(XLEN), .IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_tgt (
    .pc_i     (pc_i),
    .field_i  (imm_i),
    .seq_pc_o (seq_pc),
    .br_tgt_o (br_tgt),
    .jmp_tgt_o(jmp_tgt)
  );

  always_comb begin
    if (!act_taken)        npc_d = seq_pc;
    else if (kind == K_JMP) npc_d = jmp_tgt;
    else                   npc_d = br_tgt;
    // wrong direction, or right direction but wrong destination
    mis_d = (act_taken != pred_taken_i) ||
            (act_taken && pred_taken_i && (pred_target_i != npc_d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
      mispredict_o <= 1'b0;
    end else if (is_ctrl) begin
      res_valid_o  <= 1'b1;
      taken_o      <= act_taken;
      next_pc_o    <= npc_d;
      mispredict_o <= mis_d;
    end else begin
      res_valid_o  <= 1'b0;
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
      mispredict_o <= 1'b0;
    end
  end

  a_r6_jump_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OPC_JMP) |=> (res_valid_o && taken_o));

  a_r1_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[5:3] != 3'b100) |=> !res_valid_o);

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!res_valid_o && !taken_o && !mispredict_o));

  a_r5_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  a_r7_dir_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (mispredict_o || (taken_o == $past(pred_taken_i))));

  a_r8_flag_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> res_valid_o);
endmodule

// File: tb/sim_brn_resolve.sv
`timescale 1ns/1ps
module sim_brn_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] pc = '0;
  logic [5:0]  opc = '0;
  logic [25:0] imm = '0;
  logic [31:0] rdv = '0;
  logic [31:0] rsv = '0;
  logic        ptk = 1'b0;
  logic [31:0] ptg = '0;
  logic        res_valid, taken, mis;
  logic [31:0] npc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brn_resolve u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc), .opcode_i(opc),
    .imm_i(imm), .rd_val_i(rdv), .rs_val_i(rsv), .pred_taken_i(ptk),
    .pred_target_i(ptg), .res_valid_o(res_valid), .taken_o(taken),
    .next_pc_o(npc), .mispredict_o(mis)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, model result, compare at next negedge
  task automatic step(input string req, input logic v, input logic [5:0] o, input logic [31:0] p,
                      input logic [25:0] im, input logic [31:0] a, input logic [31:0] b,
                      input logic pt, input logic [31:0] pg);
    logic ev, et, em;
    logic [31:0] en;
    valid = v; opc = o; pc = p; imm = im; rdv = a; rsv = b; ptk = pt; ptg = pg;
    ev = 1'b0; et = 1'b0; em = 1'b0; en = '0;
    if (v && (o inside {6'b100000, 6'b100001, 6'b100010, 6'b100011, 6'b100100})) begin
      ev = 1'b1;
      case (o)
        6'b100000: et = (a == b);
        6'b100001: et = (a != b);
        6'b100010: et = ($signed(a) < $signed(b));
        6'b100011: et = ($signed(a) > $signed(b));
        default:   et = 1'b1;
      endcase
      if (!et) en = p + 32'd4;
      else if (o == 6'b100100) en = {4'b0, im, 2'b00};
      else en = p + 32'd4 + 32'($signed(im[15:0])) * 32'd4;
      em = (et != pt) || (et && pt && pg != en);
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "res_valid", {31'b0, res_valid}, {31'b0, ev});
    chk(req, "taken", {31'b0, taken}, {31'b0, et});
    chk(req, "next_pc", npc, en);
    chk(req, "mispredict", {31'b0, mis}, {31'b0, em});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "res_valid", {31'b0, res_valid}, 32'd0);
    chk("R10", "taken", {31'b0, taken}, 32'd0);
    chk("R10", "next_pc", npc, 32'd0);
    chk("R10", "mispredict", {31'b0, mis}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 equal taken, correct target predicted
    step("R2", 1, 6'b100000, 32'h100, 26'h0010, 32'd5, 32'd5, 1, 32'h144);
    // R2/R7 equal not taken but predicted taken
    step("R2", 1, 6'b100000, 32'h100, 26'h0010, 32'd5, 32'd6, 1, 32'h144);
    step("R2", 1, 6'b100001, 32'h200, 26'h0003, 32'd1, 32'd2, 0, 32'h0);
    step("R2", 1, 6'b100001, 32'h200, 26'h0003, 32'd9, 32'd9, 0, 32'h0);
    // R3 signed compares
    step("R3", 1, 6'b100010, 32'h300, 26'h0001, 32'hFFFFFFFB, 32'd3, 1, 32'h308);
    step("R3", 1, 6'b100010, 32'h300, 26'h0001, 32'd1, 32'hFFFFFFFF, 0, 32'h0);
    step("R3", 1, 6'b100011, 32'h400, 26'h0002, 32'd7, 32'hFFFFFFFE, 0, 32'h0);
    step("R3", 1, 6'b100011, 32'h400, 26'h0002, 32'd7, 32'd7, 0, 32'h0);
    // R4 backward offset, garbage high field bits
    step("R4", 1, 6'b100000, 32'h1000, 26'h3FFFFFE, 32'd0, 32'd0, 1, 32'h0FFC);
    step("R4", 1, 6'b100001, 32'h1000, 26'h2A8000, 32'd1, 32'd0, 0, 32'h0);
    // R5 fall through
    step("R5", 1, 6'b100011, 32'hFFFFFFFC, 26'h0004, 32'd0, 32'd1, 0, 32'h0);
    // R6 jumps
    step("R6", 1, 6'b100100, 32'h5000, 26'h3FFFFFF, 32'd1, 32'd2, 1, 32'h0FFFFFFC);
    step("R6", 1, 6'b100100, 32'h7777, 26'h0000040, 32'd0, 32'd0, 0, 32'h0);
    // R8 wrong target with right direction; target ignored when not predicted
    step("R8", 1, 6'b100100, 32'h0, 26'h0000100, 32'd0, 32'd0, 1, 32'h404);
    step("R8", 1, 6'b100010, 32'h20, 26'h0005, 32'd4, 32'd2, 0, 32'hDEADBEEF);
    step("R7", 1, 6'b100010, 32'h20, 26'h0005, 32'd1, 32'd2, 0, 32'h0);
    // R1 unused opcodes
    step("R1", 1, 6'b101000, 32'h40, 26'h0001, 32'd0, 32'd0, 1, 32'h48);
    step("R1", 1, 6'b100101, 32'h40, 26'h0001, 32'd0, 32'd0, 0, 32'h0);
    step("R1", 1, 6'b000000, 32'h40, 26'h0001, 32'd0, 32'd0, 1, 32'h0);
    // R9 valid low after a taken jump
    step("R9", 1, 6'b100100, 32'h0, 26'h0000010, 32'd0, 32'd0, 0, 32'h0);
    step("R9", 0, 6'b100100, 32'h0, 26'h0000010, 32'd0, 32'd0, 1, 32'h0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule